// File: doc/BRIEF.md
# Horizontal sync regenerator with clamp timing

This block sits behind the analog front end of a video digitiser and works in the pixel-clock domain. It receives the raw horizontal sync, brings it into the clock domain, and turns it into a normalised "active" sync. The sync's polarity comes either from an internal detector or from a forced configuration bit.

On each leading edge of the normalised sync, the block produces a fresh output sync pulse. The pulse has a programmable length in pixel clocks and a selectable output level. On each trailing edge it starts a clamp window: a programmable wait, then a programmable number of clocks during which the clamp is asserted. A configuration bit can replace the internal clamp with an external clamp input, which is resynchronised and passed straight through.

The configuration inputs are expected to be held steady while lines are running. Every latency below is counted in rising clock edges from the edge that first samples the changed input.

Top module: `hsync_clamp_gen`

## Requirements
- R1: Polarity source. When `pol_force` is 1, `pol_force_val` gives the active sync level (0 = active low, 1 = active high). When `pol_force` is 0, `pol_detected` gives it.
- R2: Polarity detection. On every rising edge of the synchronised raw sync, `pol_detected` becomes 1 if the sync spent fewer clocks high than low since the previous rising edge, and becomes 0 otherwise.
- R3: A leading edge of the active sync starts an output pulse. The pulse begins 3 clocks after the raw edge is first sampled and lasts `pulse_width` clocks. A `pulse_width` of 0 gives no pulse.
- R4: With `out_pol_lo` = 0 the output pulse is driven high on an idle-low `sync_out`. With `out_pol_lo` = 1 the pulse is driven low on an idle-high `sync_out`.
- R5: The internal clamp begins `clamp_delay` + 3 clocks after the raw trailing edge is first sampled. A delay of 0 starts it on the clock that registers the edge.
- R6: The internal clamp lasts `clamp_len` clocks. A `clamp_len` of 0 gives no clamp for that line.
- R7: With `clamp_ext_sel` = 1, `clamp_out` follows `ext_clamp_in` delayed by 2 clocks, and the internal clamp is not seen.
- R8: A leading edge that arrives while an output pulse is running reloads the pulse to its full width. It does not disturb a running clamp. The clamp is reloaded only by the next trailing edge, after its delay.
- R9: After reset, `sync_out` sits at its idle level, `clamp_out` is 0 and `pol_detected` is 0. No edge is reported until the synchroniser holds sampled data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Raw horizontal sync, asynchronous |
| ext_clamp_in | input | 1 | External clamp, asynchronous |
| pol_force | input | 1 | 1 = use `pol_force_val` as the active level |
| pol_force_val | input | 1 | Forced active level, 1 = active high |
| out_pol_lo | input | 1 | 1 = output pulse driven low |
| clamp_ext_sel | input | 1 | 1 = external clamp drives `clamp_out` |
| clamp_delay | input | CNT_W | Clocks from trailing edge to clamp start |
| clamp_len | input | CNT_W | Clamp length in clocks |
| pulse_width | input | CNT_W | Output sync pulse length in clocks |
| sync_out | output | 1 | Regenerated horizontal sync |
| clamp_out | output | 1 | Clamp pulse |
| pol_detected | output | 1 | Detected active level, 1 = active high |

## Verification
The output-pulse reload and the clamp window can both be active in the same cycle. The bench provokes this with a short line that follows another one closely. The second leading edge then lands while the first output pulse and the first clamp are both still running, and the second trailing edge lands during the clamp.

The scoreboard expects one merged output pulse, stretched to a full width from the second edge. It also expects one merged clamp that runs on unbroken and is reloaded only after the second trailing edge's delay. Each pulse's start cycle and length are compared with these expectations.

// File: rtl/hsync_clamp_gen.sv
module hsync_clamp_gen #(
  parameter int CNT_W  = 8,
  parameter int LINE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             ext_clamp_in,
  input  logic             pol_force,
  input  logic             pol_force_val,
  input  logic             out_pol_lo,
  input  logic             clamp_ext_sel,
  input  logic [CNT_W-1:0] clamp_delay,
  input  logic [CNT_W-1:0] clamp_len,
  input  logic [CNT_W-1:0] pulse_width,
  output logic             sync_out,
  output logic             clamp_out,
  output logic             pol_detected
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic s1, s2, s3, x1, x2;
  logic [2:0] warm;
  logic vld, act, n_cur, n_prv, lead, trail, line_mark;
  logic pol_det;
  logic [LINE_W-1:0] hi_cnt, lo_cnt;
  logic [CNT_W-1:0] pw_cnt, dly_cnt, cl_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      x1 <= 1'b0; x2 <= 1'b0;
      warm <= '0;
    end else begin
      s1 <= sync_in; s2 <= s1; s3 <= s2;
      x1 <= ext_clamp_in; x2 <= x1;
      warm <= {warm[1:0], 1'b1};
    end
  end

  assign vld       = warm[2];
  assign act       = pol_force ? pol_force_val : pol_det;
  assign n_cur     = s2 ~^ act;
  assign n_prv     = s3 ~^ act;
  assign lead      = vld & n_cur & ~n_prv;
  assign trail     = vld & ~n_cur & n_prv;
  assign line_mark = vld & s2 & ~s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_det <= 1'b0;
      hi_cnt  <= '0;
      lo_cnt  <= '0;
    end else if (line_mark) begin
      pol_det <= (hi_cnt < lo_cnt);
      hi_cnt  <= LINE_W'(1);
      lo_cnt  <= '0;
    end else if (vld) begin
      if (s2 && hi_cnt != LINE_MAX) hi_cnt <= hi_cnt + 1'b1;
      if (!s2 && lo_cnt != LINE_MAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pw_cnt <= '0;
    else if (lead)
      pw_cnt <= pulse_width;
    else if (pw_cnt != '0)
      pw_cnt <= pw_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_cnt <= '0;
      cl_cnt  <= '0;
    end else if (trail && clamp_len == '0) begin
      dly_cnt <= '0;
      cl_cnt  <= '0;
    end else if (trail && clamp_delay == '0) begin
      dly_cnt <= '0;
      cl_cnt  <= clamp_len;
    end else if (trail) begin
      dly_cnt <= clamp_delay;
      if (cl_cnt != '0) cl_cnt <= cl_cnt - 1'b1;
    end else begin
      if (dly_cnt != '0) dly_cnt <= dly_cnt - 1'b1;
      if (dly_cnt == CNT_W'(1))
        cl_cnt <= clamp_len;
      else if (cl_cnt != '0)
        cl_cnt <= cl_cnt - 1'b1;
    end
  end

  assign sync_out     = (pw_cnt != '0) ? ~out_pol_lo : out_pol_lo;
  assign clamp_out    = clamp_ext_sel ? x2 : (cl_cnt != '0);
  assign pol_detected = pol_det;

  // R9
  no_early_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> (pw_cnt == '0 && cl_cnt == '0));

  // R2
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_mark |=> $stable(pol_det));

  // R5
  clamp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cl_cnt != '0) |-> ($past(dly_cnt) == CNT_W'(1) || $past(trail)));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_cnt == '0) |-> (sync_out == out_pol_lo));

  // R7
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_ext_sel |-> (clamp_out == x2));

  // R8
  pulse_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_cnt != '0 && !lead) |=> (pw_cnt < $past(pw_cnt)));

endmodule

// File: tb/hsync_clamp_gen_tb.sv
module hsync_clamp_gen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct { int st; int ln; string rq; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_in = 1'b0, ext_clamp_in = 1'b0;
  logic pol_force = 1'b1, pol_force_val = 1'b1, out_pol_lo = 1'b0, clamp_ext_sel = 1'b0;
  logic [7:0] clamp_delay = 8'd128, clamp_len = 8'd128, pulse_width = 8'd32;
  logic sync_out, clamp_out, pol_detected;

  int cyc = 0, n_chk = 0, n_fail = 0, s_seen = 0, c_seen = 0;
  bit done = 1'b0;
  exp_t qs[$], qc[$];

  hsync_clamp_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .ext_clamp_in(ext_clamp_in),
    .pol_force(pol_force), .pol_force_val(pol_force_val), .out_pol_lo(out_pol_lo),
    .clamp_ext_sel(clamp_ext_sel), .clamp_delay(clamp_delay), .clamp_len(clamp_len),
    .pulse_width(pulse_width), .sync_out(sync_out), .clamp_out(clamp_out),
    .pol_detected(pol_detected));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // monitor
  bit s_prev = 1'b0, c_prev = 1'b0;
  int s_st = 0, c_st = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit s_act = sync_out ^ out_pol_lo;
      automatic exp_t e;
      if (s_act && !s_prev) s_st = cyc;
      if (!s_act && s_prev) begin
        s_seen++;
        if (qs.size() == 0) chk(0, "R3 unexpected sync pulse", s_st, -1);
        else begin
          e = qs.pop_front();
          chk(s_st == e.st, {e.rq, " sync start"}, s_st, e.st);
          chk(cyc - s_st == e.ln, {e.rq, " sync length"}, cyc - s_st, e.ln);
        end
      end
      if (clamp_out && !c_prev) c_st = cyc;
      if (!clamp_out && c_prev) begin
        c_seen++;
        if (qc.size() == 0) chk(0, "R6 unexpected clamp pulse", c_st, -1);
        else begin
          e = qc.pop_front();
          chk(c_st == e.st, {e.rq, " clamp start"}, c_st, e.st);
          chk(cyc - c_st == e.ln, {e.rq, " clamp length"}, cyc - c_st, e.ln);
        end
      end
      s_prev = s_act;
      c_prev = clamp_out;
    end
  end

  task automatic line(input int act_len, input int gap, input bit hi, input string rq);
    int t, u;
    exp_t e;
    t = cyc;
    sync_in = hi;
    if (pulse_width != 0) begin e.st = t + 3; e.ln = pulse_width; e.rq = rq; qs.push_back(e); end
    repeat (act_len) @(negedge clk);
    u = cyc;
    sync_in = ~hi;
    if (!clamp_ext_sel && clamp_len != 0) begin
      e.st = u + 3 + int'(clamp_delay); e.ln = clamp_len; e.rq = rq; qc.push_back(e);
    end
    repeat (gap) @(negedge clk);
  endtask

  task automatic set_pol(input bit frc, input bit val, input bit idle);
    logic [7:0] w, l;
    w = pulse_width; l = clamp_len;
    pulse_width = 0; clamp_len = 0;
    pol_force = frc; pol_force_val = val; sync_in = idle;
    repeat (10) @(negedge clk);
    pulse_width = w; clamp_len = l;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    exp_t e;
    int t, s0, c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R9 reset state
    chk(sync_out == 1'b0, "R9 sync_out idle", sync_out, 0);
    chk(clamp_out == 1'b0, "R9 clamp_out", clamp_out, 0);
    chk(pol_detected == 1'b0, "R9 pol_detected", pol_detected, 0);

    // R1 R3 R5 R6: forced active high, defaults
    line(40, 400, 1'b1, "R3/R5 defaults");

    // R1 forced active low, R5 delay 0
    set_pol(1'b1, 1'b0, 1'b1);
    pulse_width = 5; clamp_delay = 0; clamp_len = 3;
    line(12, 60, 1'b0, "R1/R5 delay0");
    line(20, 60, 1'b0, "R1 active low");

    // R4 output polarity low
    out_pol_lo = 1'b1; pulse_width = 7; clamp_delay = 1; clamp_len = 1;
    repeat (2) @(negedge clk);
    chk(sync_out == 1'b1, "R4 idle high", sync_out, 1);
    line(9, 40, 1'b0, "R4 low pulse");
    out_pol_lo = 1'b0;

    // R3 R6 zero width and zero length
    pulse_width = 0; clamp_len = 0;
    s0 = s_seen; c0 = c_seen;
    line(10, 50, 1'b0, "R3/R6 zero");
    chk(s_seen == s0, "R3 width0 no pulse", s_seen - s0, 0);
    chk(c_seen == c0, "R6 len0 no clamp", c_seen - c0, 0);

    // R7 external clamp
    pulse_width = 4; clamp_len = 6; clamp_delay = 2;
    clamp_ext_sel = 1'b1;
    repeat (3) @(negedge clk);
    line(8, 40, 1'b0, "R7 internal hidden");
    t = cyc; ext_clamp_in = 1'b1;
    e.st = t + 2; e.ln = 9; e.rq = "R7 ext"; qc.push_back(e);
    repeat (9) @(negedge clk);
    ext_clamp_in = 1'b0;
    repeat (20) @(negedge clk);
    clamp_ext_sel = 1'b0;

    // R8 restart: lines overlap running pulse and clamp
    set_pol(1'b1, 1'b1, 1'b0);
    pulse_width = 20; clamp_delay = 2; clamp_len = 30;
    t = cyc;
    e.st = t + 3;  e.ln = 30; e.rq = "R8 sync reload";  qs.push_back(e);
    e.st = t + 9;  e.ln = 40; e.rq = "R8 clamp merged"; qc.push_back(e);
    sync_in = 1'b1; repeat (4) @(negedge clk);
    sync_in = 1'b0; repeat (6) @(negedge clk);
    sync_in = 1'b1; repeat (4) @(negedge clk);
    sync_in = 1'b0; repeat (80) @(negedge clk);

    // R2 detection, outputs silenced
    pulse_width = 0; clamp_len = 0;
    pol_force = 1'b0; sync_in = 1'b1;
    for (int i = 0; i < 3; i++) line(10, 60, 1'b0, "R2");
    chk(pol_detected == 1'b0, "R2 active low detected", pol_detected, 0);
    sync_in = 1'b0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 3; i++) line(10, 60, 1'b1, "R2");
    chk(pol_detected == 1'b1, "R2 active high detected", pol_detected, 1);

    // R1 auto source drives the pulses
    pulse_width = 6; clamp_delay = 4; clamp_len = 5;
    line(10, 60, 1'b1, "R1 auto");

    repeat (50) @(negedge clk);
    chk(qs.size() == 0, "R3 sync queue drained", qs.size(), 0);
    chk(qc.size() == 0, "R6 clamp queue drained", qc.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule